// File: doc/BRIEF.md
# Flash Sector Protection Register Unit

This unit is the control and status register front of a serial NOR flash controller. Software reaches it over a simple 32-bit register port. Through that port it issues erase commands, sets a protected region and handles two interrupt causes. The protected region is stored as a 4-bit protect level plus a top/bottom select. From these the unit derives a power-of-two span of 64 KiB sectors, anchored either at address zero or at the top of the device.

Every memory-side write is checked against the region in the same cycle. A write that lands in the region is withheld from the data path and raises a sticky illegal-write flag. Sector and bulk erase commands are checked in the same way. An erase that passes the check goes out on a valid/ready request port, and the unit stays busy until the backend answers with a done pulse. An erase that fails the check is dropped and raises a sticky illegal-erase flag. The interrupt line is the masked OR of the two flags.

Top module: `flash_guard_csr`

## Requirements
- R1: After reset the status word, the interrupt flags, the interrupt mask, `irq` and `er_valid` are all 0.
- R2: Register index 1 is a read-only identity word. Its low byte is SIZE_LOG2+6, so the device holds 2^(low byte − 6) bytes, and all its other bits are 0.
- R3: A write to register index 2 with bits [1:0]=3 sets the protect level from bits [11:8] and the top/bottom select from bit 12. A level of 0 also clears the select. Status register index 0 shows level bits 2..0 at bits 4:2, the select at bit 5 and level bit 3 at bit 6.
- R4: For a level L above 0, the region spans 2^(L−1) sectors of 64 KiB, capped at the whole device. With the select at 1 it starts at address 0; with the select at 0 it ends at the top of the device. Level 0 protects nothing.
- R5: When `mem_wr` is high, `mem_wr_pass` follows it only if the sector of `mem_addr` lies outside the region. A write inside the region sets interrupt flag bit 1 at that clock edge.
- R6: A register write to index 2 with bits [1:0]=2 requests an erase of the sector held in bits [8+:SECT_W]. A sector outside the region is issued with `er_valid`=1, `er_sector` set to that sector and `er_bulk`=0. A sector inside the region is not issued and sets interrupt flag bit 0.
- R7: A register write to index 2 with bits [1:0]=1 is a bulk erase. It is issued with `er_bulk`=1 only when the level is 0; otherwise it is not issued and sets interrupt flag bit 0.
- R8: `er_valid`, `er_sector` and `er_bulk` hold steady until `er_ready` is seen. Status bit 0 (busy) is 1 from the edge that accepts an erase until the edge that samples `er_done`.
- R9: While busy, every write to register index 2 is ignored: protect settings and the pending request are unchanged.
- R10: The interrupt flags at register index 3 are sticky. Writing a 1 to a bit clears it, and writing a 0 leaves it alone. A new event in the same cycle as a clear leaves the flag set.
- R11: `irq` is the OR of the flags ANDed with the mask at register index 4, bits [1:0]. The mask reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_wr | input | 1 | Memory-side write request |
| mem_addr | input | SIZE_LOG2 | Byte address of the memory-side write |
| mem_wr_pass | output | 1 | Memory write allowed through to the data path |
| er_valid | output | 1 | Erase request valid |
| er_ready | input | 1 | Backend accepts the erase request |
| er_sector | output | SIZE_LOG2-16 | Sector to erase |
| er_bulk | output | 1 | Request is a whole-device erase |
| er_done | input | 1 | Backend finished the erase |
| irq | output | 1 | Masked interrupt |

## Verification
Each of the sixteen levels is tried with both top/bottom selects. For every combination, one memory write and one sector erase go to each of the sixteen sectors, and the expected region is computed arithmetically. Together these separate bottom-anchored from top-anchored spans, catch off-by-one errors at the region edge, and expose the cap at the device size for the largest levels. A bulk erase per combination checks that any nonzero level blocks it. Separate runs stall `er_ready` to check that the request holds steady, write to the operation register while busy, raise an event in the same cycle as its clear, and sweep every mask against every flag pattern.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int SECT_LOG2 = 16;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_BULK = 2'd1,
        OP_SECT = 2'd2,
        OP_PROT = 2'd3
    } op_e;

    typedef struct packed {
        logic [3:0] lvl;
        logic       tb;
    } prot_t;

    localparam logic [2:0] RA_STATUS = 3'd0;
    localparam logic [2:0] RA_ID     = 3'd1;
    localparam logic [2:0] RA_OP     = 3'd2;
    localparam logic [2:0] RA_FLAGS  = 3'd3;
    localparam logic [2:0] RA_MASK   = 3'd4;

    function automatic logic [31:0] status_word(prot_t p, logic busy);
        logic [31:0] w;
        w      = '0;
        w[0]   = busy;
        w[4:2] = p.lvl[2:0];
        w[5]   = p.tb;
        w[6]   = p.lvl[3];
        return w;
    endfunction

    // Sector inside the region described by p, for a device of 2^nlog2 sectors
    function automatic logic prot_hit(prot_t p, int unsigned sect, int unsigned nlog2);
        int unsigned shamt;
        int unsigned span;
        int unsigned total;
        if (p.lvl == 4'd0) return 1'b0;
        shamt = 32'(p.lvl) - 32'd1;
        if (shamt >= nlog2) return 1'b1;
        span  = 32'd1 << shamt;
        total = 32'd1 << nlog2;
        if (p.tb) return sect < span;
        return sect >= (total - span);
    endfunction

endpackage

// File: rtl/flash_guard_region.sv
module flash_guard_region
    import flash_guard_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  prot_t             prot,
    input  logic [SECT_W-1:0] sect,
    output logic              hit
);
    assign hit = prot_hit(prot, 32'(sect), SECT_W);
endmodule

// File: rtl/flash_guard_cmd.sv
module flash_guard_cmd
    import flash_guard_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_wr,
    input  logic [31:0]       op_data,
    input  logic              er_ready,
    input  logic              er_done,
    output prot_t             prot,
    output logic              busy,
    output logic              er_valid,
    output logic [SECT_W-1:0] er_sector,
    output logic              er_bulk,
    output logic              ill_erase
);
    op_e               opc;
    logic [SECT_W-1:0] req_sect;
    logic              req_hit;
    logic              start_sect;
    logic              start_bulk;
    logic              set_prot;

    assign opc      = op_e'(op_data[1:0]);
    assign req_sect = op_data[8 +: SECT_W];

    flash_guard_region #(.SECT_W(SECT_W)) i_req_region (
        .prot (prot),
        .sect (req_sect),
        .hit  (req_hit)
    );

    always_comb begin
        start_sect = 1'b0;
        start_bulk = 1'b0;
        set_prot   = 1'b0;
        ill_erase  = 1'b0;
        if (op_wr && !busy) begin
            case (opc)
                OP_SECT: begin
                    if (req_hit) ill_erase  = 1'b1;
                    else         start_sect = 1'b1;
                end
                OP_BULK: begin
                    if (prot.lvl != 4'd0) ill_erase  = 1'b1;
                    else                  start_bulk = 1'b1;
                end
                OP_PROT: set_prot = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prot      <= '0;
            busy      <= 1'b0;
            er_valid  <= 1'b0;
            er_sector <= '0;
            er_bulk   <= 1'b0;
        end else begin
            if (er_valid && er_ready) er_valid <= 1'b0;
            if (er_done)              busy     <= 1'b0;
            if (start_sect || start_bulk) begin
                busy      <= 1'b1;
                er_valid  <= 1'b1;
                er_bulk   <= start_bulk;
                er_sector <= start_bulk ? '0 : req_sect;
            end
            if (set_prot) begin
                prot.lvl <= op_data[11:8];
                prot.tb  <= (op_data[11:8] != 4'd0) ? op_data[12] : 1'b0;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        er_valid && !er_ready |=> er_valid && $stable(er_sector) && $stable(er_bulk)); // R8
    AST_VALID_UNDER_BUSY: assert property (@(posedge clk) disable iff (rst)
        er_valid |-> busy); // R8
    AST_BULK_OPEN_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(er_valid) && er_bulk |-> prot.lvl == 4'd0); // R7
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        busy && !er_done |=> $stable(prot)); // R9
endmodule

// File: rtl/flash_guard_irq.sv
module flash_guard_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_erase,
    input  logic       set_write,
    input  logic       flag_wr,
    input  logic [1:0] flag_wdata,
    input  logic       mask_wr,
    input  logic [1:0] mask_wdata,
    output logic [1:0] flags,
    output logic [1:0] mask,
    output logic       irq
);
    logic [1:0] clr;

    assign clr = flag_wr ? flag_wdata : 2'b00;
    assign irq = |(flags & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= 2'b00;
            mask  <= 2'b00;
        end else begin
            flags <= (flags & ~clr) | {set_write, set_erase};
            if (mask_wr) mask <= mask_wdata;
        end
    end

    AST_ERASE_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags[0] && !(flag_wr && flag_wdata[0]) |=> flags[0]); // R10
    AST_WRITE_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags[1] && !(flag_wr && flag_wdata[1]) |=> flags[1]); // R10
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        set_erase |=> flags[0]); // R10
endmodule

// File: rtl/flash_guard_csr.sv
module flash_guard_csr
    import flash_guard_pkg::*;
#(
    parameter int SIZE_LOG2 = 20
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [2:0]                     reg_addr,
    input  logic                           reg_wr,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    input  logic                           mem_wr,
    input  logic [SIZE_LOG2-1:0]           mem_addr,
    output logic                           mem_wr_pass,
    output logic                           er_valid,
    input  logic                           er_ready,
    output logic [SIZE_LOG2-SECT_LOG2-1:0] er_sector,
    output logic                           er_bulk,
    input  logic                           er_done,
    output logic                           irq
);
    localparam int SECT_W = SIZE_LOG2 - SECT_LOG2;
    localparam logic [7:0] ID_BYTE = 8'(SIZE_LOG2 + 6);

    prot_t       prot;
    logic        busy;
    logic        ill_erase;
    logic        ill_write;
    logic        wr_hit;
    logic        iss_hit;
    logic [1:0]  flags;
    logic [1:0]  mask;

    flash_guard_cmd #(.SECT_W(SECT_W)) i_cmd (
        .clk       (clk),
        .rst       (rst),
        .op_wr     (reg_wr && reg_addr == RA_OP),
        .op_data   (reg_wdata),
        .er_ready  (er_ready),
        .er_done   (er_done),
        .prot      (prot),
        .busy      (busy),
        .er_valid  (er_valid),
        .er_sector (er_sector),
        .er_bulk   (er_bulk),
        .ill_erase (ill_erase)
    );

    flash_guard_region #(.SECT_W(SECT_W)) i_wr_region (
        .prot (prot),
        .sect (mem_addr[SIZE_LOG2-1 -: SECT_W]),
        .hit  (wr_hit)
    );

    flash_guard_region #(.SECT_W(SECT_W)) i_iss_region (
        .prot (prot),
        .sect (er_sector),
        .hit  (iss_hit)
    );

    assign ill_write   = mem_wr && wr_hit;
    assign mem_wr_pass = mem_wr && !wr_hit;

    flash_guard_irq i_irq (
        .clk        (clk),
        .rst        (rst),
        .set_erase  (ill_erase),
        .set_write  (ill_write),
        .flag_wr    (reg_wr && reg_addr == RA_FLAGS),
        .flag_wdata (reg_wdata[1:0]),
        .mask_wr    (reg_wr && reg_addr == RA_MASK),
        .mask_wdata (reg_wdata[1:0]),
        .flags      (flags),
        .mask       (mask),
        .irq        (irq)
    );

    always_comb begin
        case (reg_addr)
            RA_STATUS: reg_rdata = status_word(prot, busy);
            RA_ID:     reg_rdata = {24'd0, ID_BYTE};
            RA_FLAGS:  reg_rdata = {30'd0, flags};
            RA_MASK:   reg_rdata = {30'd0, mask};
            default:   reg_rdata = 32'd0;
        endcase
    end

    AST_BLOCKED_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        mem_wr && !mem_wr_pass |=> flags[1]); // R5
    AST_ISSUED_SECTOR_OPEN: assert property (@(posedge clk) disable iff (rst)
        $rose(er_valid) && !er_bulk |-> !iss_hit); // R6
    AST_PASS_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_wr_pass |-> mem_wr); // R5
endmodule

// File: tb/test_flash_guard_csr.sv
module test_flash_guard_csr;
    localparam int SL = 20;
    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_wr;
    logic [SL-1:0] mem_addr;
    logic        mem_wr_pass;
    logic        er_valid;
    logic        er_ready;
    logic [3:0]  er_sector;
    logic        er_bulk;
    logic        er_done;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    flash_guard_csr #(.SIZE_LOG2(SL)) i_flash_guard_csr (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wr_pass(mem_wr_pass), .er_valid(er_valid),
        .er_ready(er_ready), .er_sector(er_sector), .er_bulk(er_bulk),
        .er_done(er_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic exp_hit(int lvl, int tb, int s);
        int span;
        if (lvl == 0) return 1'b0;
        span = (lvl - 1 >= 4) ? NS : (1 << (lvl - 1));
        if (tb != 0) return s < span;
        return s >= NS - span;
    endfunction

    function automatic logic [31:0] exp_status(int lvl, int tb, int busy);
        return 32'(busy) | (32'(lvl & 7) << 2) | (32'(tb) << 5) | (32'((lvl >> 3) & 1) << 6);
    endfunction

    task automatic finish_erase(input string req);
        logic [31:0] st;
        @(negedge clk); er_ready = 1'b1;
        @(negedge clk); er_ready = 1'b0;
        chk({req, " valid drops after ready"}, 32'(er_valid), 0);
        @(negedge clk); er_done = 1'b1;
        @(negedge clk); er_done = 1'b0;
        rd(3'd0, st);
        chk({req, " busy clears after done"}, st[0], 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        mem_wr = 1'b0; mem_addr = '0; er_ready = 1'b0; er_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk("R1 status", v, 0);
        rd(3'd3, v); chk("R1 flags", v, 0);
        rd(3'd4, v); chk("R1 mask", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 er_valid", 32'(er_valid), 0);
        // R2 identity
        rd(3'd1, v); chk("R2 id", v, 32'(SL + 6));

        for (int lvl = 0; lvl < 16; lvl++) begin
            for (int tb = 0; tb < 2; tb++) begin
                wr(3'd2, (32'(tb) << 12) | (32'(lvl) << 8) | 32'd3);
                rd(3'd0, v);
                chk("R3 status encoding", v, exp_status(lvl, (lvl == 0) ? 0 : tb, 0));
                for (int s = 0; s < NS; s++) begin
                    logic h;
                    h = exp_hit(lvl, tb, s);
                    // R4 R5 memory write gating per sector
                    @(negedge clk);
                    mem_addr = SL'((s << 16) | ((s * 4099) & 16'hffff));
                    mem_wr = 1'b1;
                    #1 chk("R4 R5 write pass", 32'(mem_wr_pass), 32'(!h));
                    @(negedge clk);
                    mem_wr = 1'b0;
                    rd(3'd3, v);
                    chk("R5 illegal write flag", v, h ? 32'd2 : 32'd0);
                    if (h) wr(3'd3, 32'd2);
                    // R4 R6 sector erase per sector
                    wr(3'd2, (32'(s) << 8) | 32'd2);
                    if (h) begin
                        rd(3'd3, v);
                        chk("R6 illegal erase flag", v, 32'd1);
                        chk("R6 blocked not issued", 32'(er_valid), 0);
                        wr(3'd3, 32'd1);
                    end else begin
                        chk("R6 issued", 32'(er_valid), 1);
                        chk("R6 sector", 32'(er_sector), 32'(s));
                        chk("R6 not bulk", 32'(er_bulk), 0);
                        rd(3'd0, v);
                        chk("R8 busy set", v[0], 1);
                        finish_erase("R8");
                    end
                end
                // R7 bulk erase
                wr(3'd2, 32'd1);
                if (lvl != 0) begin
                    chk("R7 bulk blocked", 32'(er_valid), 0);
                    rd(3'd3, v);
                    chk("R7 bulk illegal flag", v, 32'd1);
                    wr(3'd3, 32'd1);
                end else begin
                    chk("R7 bulk issued", 32'(er_valid), 1);
                    chk("R7 bulk flag", 32'(er_bulk), 1);
                    finish_erase("R7");
                end
            end
        end

        // R8 stall, R9 writes while busy
        wr(3'd2, 32'd3);
        wr(3'd2, (32'd5 << 8) | 32'd2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 hold valid", 32'(er_valid), 1);
            chk("R8 hold sector", 32'(er_sector), 5);
        end
        wr(3'd2, (32'd1 << 12) | (32'd4 << 8) | 32'd3);
        rd(3'd0, v); chk("R9 protect ignored while busy", v, exp_status(0, 0, 1));
        wr(3'd2, (32'd7 << 8) | 32'd2);
        chk("R9 erase ignored while busy", 32'(er_sector), 5);
        @(negedge clk); er_ready = 1'b1;
        @(negedge clk); er_ready = 1'b0;
        rd(3'd0, v); chk("R8 busy until done", v[0], 1);
        @(negedge clk); er_done = 1'b1;
        @(negedge clk); er_done = 1'b0;
        rd(3'd0, v); chk("R8 busy cleared", v, 0);

        // R10 sticky flags
        wr(3'd2, (32'd15 << 8) | 32'd3);
        @(negedge clk); mem_addr = '0; mem_wr = 1'b1;
        @(negedge clk); mem_wr = 1'b0;
        wr(3'd3, 32'd1);
        rd(3'd3, v); chk("R10 other bit clear leaves flag", v, 2);
        wr(3'd3, 32'd0);
        rd(3'd3, v); chk("R10 zero write leaves flag", v, 2);
        @(negedge clk);
        mem_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd2; reg_wr = 1'b1;
        @(negedge clk);
        mem_wr = 1'b0; reg_wr = 1'b0;
        rd(3'd3, v); chk("R10 set wins over clear", v, 2);
        wr(3'd3, 32'd2);
        rd(3'd3, v); chk("R10 clear", v, 0);

        // R11 mask sweep
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 4; f++) begin
                wr(3'd3, 32'd3);
                if ((f & 1) != 0) wr(3'd2, 32'd1);
                if ((f & 2) != 0) begin
                    @(negedge clk); mem_wr = 1'b1;
                    @(negedge clk); mem_wr = 1'b0;
                end
                wr(3'd4, 32'(m));
                rd(3'd4, v); chk("R11 mask readback", v, 32'(m));
                rd(3'd3, v); chk("R11 flags", v, 32'(f));
                chk("R11 irq", 32'(irq), 32'((f & m) != 0));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule